// File: doc/BRIEF.md
# Comparator-Loop Delta-Sigma Converter

This block turns an analog voltage into multi-bit samples using only a differential input pair used as a comparator and an external resistor-capacitor network. Every clock cycle a flip-flop captures the comparator's decision. That same bit drives an output pin that charges or discharges the RC node. The RC voltage therefore follows the input and closes a first-order modulator loop. The comparator reads 1 when the analog input is above the RC voltage and 0 otherwise.

The resulting one-bit stream feeds a cascaded integrator-comb decimator of order N (default 3) with decimation ratio R (default 64, a power of two). Once every R clocks the decimator emits one unsigned word. On this scale, a bitstream of all ones reads full scale, R to the power N. The accumulators are N*log2(R)+1 bits wide and rely on two's-complement wraparound. The design targets signals in the tens of kHz, with the clock acting as the modulator's sample clock.

Top module: `dsadc_top`

## Requirements
- R1: A synchronous reset drives fb_out, sample_valid and sample_out to 0 and clears all integrator, comb and counter state.
- R2: fb_out equals the value cmp_in had at the previous rising clock edge: 1 when the input was above the RC voltage, 0 otherwise.
- R3: sample_valid is a single-cycle pulse, and consecutive pulses are exactly R clocks apart.
- R4: After the filter has settled, a constant cmp_in of 1 gives sample_out = R^N (262144 by default), and a constant 0 gives 0.
- R5: After settling, a periodic cmp_in whose period divides R and whose ones density is d gives sample_out = d*R^N. Density 1/2 gives 131072 and density 1/4 gives 65536 by default.
- R6: sample_out never exceeds R^N.
- R7: The integrators wrap modulo 2^(N*log2(R)+1) with no saturation. Outputs stay exact over long runs in which the integrators overflow many times.
- R8: With fb_out closing the loop through a first-order RC model, the average of sample_out tracks vin/vref*R^N within 2 % of full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Comparator result, 1 when the analog input is above the RC voltage |
| fb_out | output | 1 | Feedback drive to the RC network, the registered comparator bit |
| sample_out | output | N*log2(R)+1 | Decimated unsigned sample, valid while sample_valid is high |
| sample_valid | output | 1 | One-cycle strobe for each decimated word |

## Verification
A stuck or wrong feedback register shows at fb_out one cycle after the comparator bit that caused it, and it also pulls the closed-loop average away from the input level. A damaged integrator or comb stage gives no visible symptom until the next strobe. It then shows as a wrong word at that strobe, or as a word that drifts across strobes, under constant or periodic bit patterns whose exact value is known. A wrong decimation counter moves the strobe, and the strobe spacing exposes this within one or two output periods.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  // Accumulator width: bit growth of an order-n CIC with ratio 2**logr, plus a sign bit.
  function automatic int cic_width(input int n, input int logr);
    return n * logr + 1;
  endfunction

  // Full-scale output word (all-ones bitstream): R^N = 2**(n*logr).
  function automatic longint full_scale(input int n, input int logr);
    return longint'(1) << (n * logr);
  endfunction

endpackage

// File: rtl/dsadc_sampler.sv
module dsadc_sampler (
  input  logic clk,
  input  logic rst,
  input  logic cmp_in,
  output logic bit_q
);

  always_ff @(posedge clk) begin
    if (rst) bit_q <= 1'b0;
    else     bit_q <= cmp_in;
  end

  // R2: the feedback drive follows the comparator one cycle later
  a_r2_fb_high: assert property (@(posedge clk) disable iff (rst) cmp_in |=> bit_q);
  a_r2_fb_low:  assert property (@(posedge clk) disable iff (rst) !cmp_in |=> !bit_q);

endmodule

// File: rtl/dsadc_integrators.sv
module dsadc_integrators #(
  parameter int N = 3,
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         din,
  output logic [W-1:0] acc_out
);

  logic [W-1:0] acc [N];

  // R7: plain modular adders; overflow wraps and cancels in the comb stages
  for (genvar k = 0; k < N; k++) begin : g_int
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) acc[k] <= '0;
        else     acc[k] <= acc[k] + {{(W-1){1'b0}}, din};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) acc[k] <= '0;
        else     acc[k] <= acc[k] + acc[k-1];
      end
    end
  end

  assign acc_out = acc[N-1];

endmodule

// File: rtl/dsadc_decimator.sv
module dsadc_decimator #(
  parameter int N     = 3,
  parameter int LOG2R = 6,
  parameter int W     = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] acc_in,
  output logic [W-1:0] word_out,
  output logic         word_valid
);

  localparam int R = 1 << LOG2R;

  logic [LOG2R-1:0] phase;
  logic             dec_tick;
  logic [W-1:0]     stage [N+1];
  logic [W-1:0]     dly   [N];

  assign dec_tick = (phase == LOG2R'(R - 1));

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + 1'b1;
  end

  assign stage[0] = acc_in;

  for (genvar k = 0; k < N; k++) begin : g_comb
    assign stage[k+1] = stage[k] - dly[k];
    always_ff @(posedge clk) begin
      if (rst)           dly[k] <= '0;
      else if (dec_tick) dly[k] <= stage[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= dec_tick;
      if (dec_tick) word_out <= stage[N];
    end
  end

  // R3: strobe spacing, counted in the checker, not by a deep $past
  logic [LOG2R:0] since_v;
  logic           seen_v;
  always_ff @(posedge clk) begin
    if (rst) begin
      since_v <= '0;
      seen_v  <= 1'b0;
    end else if (word_valid) begin
      since_v <= (LOG2R+1)'(1);
      seen_v  <= 1'b1;
    end else if (since_v <= (LOG2R+1)'(R)) begin
      since_v <= since_v + 1'b1;
    end
  end

  a_r3_valid_spacing: assert property (@(posedge clk) disable iff (rst)
    (word_valid && seen_v) |-> (since_v == (LOG2R+1)'(R)));
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

endmodule

// File: rtl/dsadc_top.sv
module dsadc_top
  import dsadc_pkg::*;
#(
  parameter int N     = 3,
  parameter int R     = 64,
  parameter int LOG2R = $clog2(R),
  parameter int W     = cic_width(N, LOG2R)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmp_in,
  output logic         fb_out,
  output logic [W-1:0] sample_out,
  output logic         sample_valid
);

  localparam logic [W-1:0] FS = W'(full_scale(N, LOG2R));

  logic         mod_bit;
  logic [W-1:0] int_tail;

  dsadc_sampler u_sampler (
    .clk    (clk),
    .rst    (rst),
    .cmp_in (cmp_in),
    .bit_q  (mod_bit)
  );

  dsadc_integrators #(.N(N), .W(W)) u_int (
    .clk     (clk),
    .rst     (rst),
    .din     (mod_bit),
    .acc_out (int_tail)
  );

  dsadc_decimator #(.N(N), .LOG2R(LOG2R), .W(W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .acc_in     (int_tail),
    .word_out   (sample_out),
    .word_valid (sample_valid)
  );

  assign fb_out = mod_bit;

  // R1: reset clears the visible outputs on the following cycle
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!fb_out && !sample_valid && sample_out == '0));

  // R6: a one-bit stream cannot exceed full scale
  a_r6_full_scale_bound: assert property (@(posedge clk) disable iff (rst)
    sample_out <= FS);

endmodule

// File: tb/dsadc_top_tb_top.sv
module dsadc_top_tb_top;

  localparam int N  = 3;
  localparam int R  = 64;
  localparam int W  = 19;
  localparam longint FS = 262144;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_in = 1'b0;
  logic fb_out;
  logic [W-1:0] sample_out;
  logic sample_valid;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  dsadc_top #(.N(N), .R(R)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .cmp_in       (cmp_in),
    .fb_out       (fb_out),
    .sample_out   (sample_out),
    .sample_valid (sample_valid)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cmp_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cmp_in = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 fb_out", fb_out, 0);
    check("R1 sample_valid", sample_valid, 0);
    check("R1 sample_out", sample_out, 0);
    rst = 1'b0;
  endtask

  task automatic t_feedback();
    logic [7:0] lfsr = 8'hA5;
    logic prev;
    do_reset();
    prev = 1'b0;
    for (int i = 0; i < 40; i++) begin
      cmp_in = lfsr[0];
      prev = lfsr[0];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      @(negedge clk);
      check("R2 fb_out follows cmp_in", fb_out, prev);
    end
  endtask

  // Drive a periodic pattern (ones out of period); check strobe spacing and settled words.
  task automatic t_pattern(input string req, input int period, input int ones,
                           input int nwords, input longint exp);
    int cyc = 0;
    int last = -1;
    int words = 0;
    do_reset();
    while (words < nwords) begin
      cmp_in = ((cyc % period) < ones);
      @(negedge clk);
      cyc++;
      if (sample_valid) begin
        words++;
        if (last >= 0) check("R3 strobe spacing", cyc - last, R);
        last = cyc;
        if (words > 5) begin
          check(req, sample_out, exp);
          check("R6 bound", (longint'(sample_out) <= FS) ? 1 : 0, 1);
        end
      end
    end
    @(negedge clk);
    check("R3 single-cycle strobe", sample_valid, 0);
  endtask

  // Closed loop: first-order RC node driven by fb_out, comparator against vin.
  task automatic t_loop(input real vin);
    real vrc = 0.0;
    real sum = 0.0;
    int words = 0;
    longint exp;
    longint avg;
    do_reset();
    while (words < 25) begin
      cmp_in = (vin > vrc);
      @(negedge clk);
      vrc = vrc + ((fb_out ? 1.0 : 0.0) - vrc) * 0.02;
      if (sample_valid) begin
        words++;
        if (words > 5) sum = sum + real'(sample_out);
      end
    end
    avg = longint'(sum / 20.0);
    exp = longint'(vin * real'(FS));
    n_checks++;
    if (avg > exp + FS / 50 || avg < exp - FS / 50) begin
      n_fail++;
      $display("FAIL R8 loop average actual=%0d expected=%0d", avg, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_feedback();
    t_pattern("R4 all ones", 1, 1, 10, FS);
    t_pattern("R4 all zeros", 1, 0, 10, 0);
    t_pattern("R5 half density", 2, 1, 10, FS / 2);
    t_pattern("R5 quarter density", 4, 1, 10, FS / 4);
    t_pattern("R5 three quarter density", 4, 3, 10, (FS * 3) / 4);
    t_pattern("R7 long run with integrator wrap", 1, 1, 60, FS);
    t_loop(0.30);
    t_loop(0.70);
    t_reset();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule